// File: doc/BRIEF.md
# Row-Addressed Configuration Programming Register

This block loads configuration memory one full row at a time. A wide word is shifted in one bit per enabled clock. The word carries eight ignored padding bits, a 6-bit row address and 260 column bits. An update strobe then decodes the address into a single word line and writes all 260 column bits of that row in one cycle. The columns fall into five regions, left to right: 10, 112, 16, 112 and 10 bits wide. They are stored as one flat 260-bit row. A select input chooses the destination: the volatile configuration store, or a modelled nonvolatile store with the same 49-row shape.

The bit at the far end of the register is driven onto a serial output, so several such registers can be chained. A capture strobe copies the addressed row of the chosen store into the data field of the register. Shifting the register out afterwards gives readback. A boot-copy command moves every nonvolatile row into the volatile store, one row per clock, which models power-up loading. Both stores can also be read directly through a row-select read port.

Top module: `cfg_row_prog`

## Requirements
- R1: With `shiftEn` high, the register moves one place toward bit 0 and `serIn` enters at bit 273. `serOut` always shows bit 0, so the first bit shifted in appears at `serOut` after all 274 shifts.
- R2: Field layout, shifted least significant bit first: bits 7:0 are padding, bits 13:8 are the row address (LSB at bit 8), and bits 273:14 are column data (column 0 at bit 14).
- R3: An `updateStb` pulse with `targetNv` low and an address below 49 writes the data field into that row of the volatile store. The row is visible on `rdData` from the next cycle.
- R4: With `targetNv` high, the update writes the nonvolatile store only, and the volatile store is left unchanged.
- R5: An update whose address is 49 or above writes no row of either store.
- R6: The padding bits have no effect on which row is written or on the data written.
- R7: A `captureStb` pulse with an address below 49 replaces the data field with the addressed row of the store chosen by `targetNv`, leaving address and padding bits unchanged. Capture takes priority over shifting in the same cycle.
- R8: After reset both stores and the register are all zeros. `rdData` reads zero for any `rdRow` of 49 or above.
- R9: A `bootCopy` pulse while idle raises `copyBusy` in the next cycle. The block then copies volatile row n from nonvolatile row n on its n-th busy cycle, and `copyBusy` stays high for exactly 49 cycles.
- R10: While `copyBusy` is high, `updateStb`, `captureStb` and further `bootCopy` pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| shiftEn | input | 1 | Shift one bit this cycle |
| serIn | input | 1 | Serial data in |
| serOut | output | 1 | Serial data out (register bit 0) |
| updateStb | input | 1 | Write the addressed row |
| captureStb | input | 1 | Load the addressed row into the data field |
| targetNv | input | 1 | 1 selects the nonvolatile store, 0 the volatile store |
| bootCopy | input | 1 | Start the copy of all nonvolatile rows into the volatile store |
| copyBusy | output | 1 | Copy in progress |
| rdNv | input | 1 | Read port store select (1 = nonvolatile) |
| rdRow | input | 6 | Read port row |
| rdData | output | 260 | Contents of the selected row |

## Verification
Each shift, update, capture or copy step lands on the clock edge where its strobe is sampled. The register bit, the written row and `copyBusy` therefore change right after that edge, and `rdData` follows with no further delay because it is a combinational read of the stores. Inputs are driven 1 ns after a rising edge. A behavioural model advances on the same rising edge, and outputs are compared on the falling edge, half a cycle after every result is due. Readback through `serOut` is checked bit by bit: each bit is sampled just after the edge that exposes it.

// File: rtl/cfg_row_pkg.sv
package cfg_row_pkg;
  localparam int PAD_W  = 8;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 260;
  localparam int ROWS   = 49;
  localparam int WORD_W = PAD_W + ADDR_W + DATA_W;
  localparam int DATA_LSB = PAD_W + ADDR_W;

  typedef struct packed {
    logic              doShift;
    logic              doCapture;
    logic              doWrite;
    logic              toNv;
    logic              doCopy;
    logic [ADDR_W-1:0] copyRow;
  } ctrl_t;
endpackage

// File: rtl/cfg_row_ctrl.sv
module cfg_row_ctrl
  import cfg_row_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  shiftEn,
  input  logic  updateStb,
  input  logic  captureStb,
  input  logic  targetNv,
  input  logic  bootCopy,
  output ctrl_t ctl,
  output logic  copyBusy
);
  localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(ROWS - 1);

  logic              busy;
  logic [ADDR_W-1:0] row;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      row  <= '0;
    end else if (busy) begin
      if (row == LAST_ROW) begin
        busy <= 1'b0;
        row  <= '0;
      end else begin
        row <= row + 1'b1;
      end
    end else if (bootCopy) begin
      busy <= 1'b1;
      row  <= '0;
    end
  end

  always_comb begin
    ctl.doCapture = captureStb & ~busy;
    ctl.doShift   = shiftEn & ~ctl.doCapture;
    ctl.doWrite   = updateStb & ~busy;
    ctl.toNv      = targetNv;
    ctl.doCopy    = busy;
    ctl.copyRow   = row;
  end

  assign copyBusy = busy;

  p_copy_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && row == LAST_ROW) |=> !busy);
  p_copy_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && row != LAST_ROW) |=> (busy && row == $past(row) + 1'b1));
  p_copy_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && bootCopy) |=> (busy && row == '0));
endmodule

// File: rtl/cfg_row_store.sv
module cfg_row_store
  import cfg_row_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic              serIn,
  output logic              serOut,
  input  logic              rdNv,
  input  logic [ADDR_W-1:0] rdRow,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] ROW_LIMIT = ADDR_W'(ROWS);

  logic [WORD_W-1:0] shReg;
  logic [DATA_W-1:0] sramMem [ROWS];
  logic [DATA_W-1:0] nvMem   [ROWS];
  logic [ROWS-1:0]   wordLine;

  logic [ADDR_W-1:0] rowAddr;
  logic [DATA_W-1:0] rowData;
  logic              addrOk;
  logic [ADDR_W-1:0] capIdx;
  logic [DATA_W-1:0] capData;

  assign rowAddr = shReg[PAD_W +: ADDR_W];
  assign rowData = shReg[DATA_LSB +: DATA_W];
  assign addrOk  = rowAddr < ROW_LIMIT;
  assign capIdx  = addrOk ? rowAddr : '0;
  assign capData = ctl.toNv ? nvMem[capIdx] : sramMem[capIdx];

  for (genvar r = 0; r < ROWS; r++) begin : g_wl
    assign wordLine[r] = ctl.doWrite && addrOk && (rowAddr == ADDR_W'(r));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (ctl.doCapture) begin
      if (addrOk) shReg[DATA_LSB +: DATA_W] <= capData;
    end else if (ctl.doShift) begin
      shReg <= {serIn, shReg[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (!rstN) begin
        sramMem[r] <= '0;
        nvMem[r]   <= '0;
      end else begin
        if (ctl.doCopy && ctl.copyRow == ADDR_W'(r))
          sramMem[r] <= nvMem[r];
        else if (wordLine[r] && !ctl.toNv)
          sramMem[r] <= rowData;
        if (wordLine[r] && ctl.toNv)
          nvMem[r] <= rowData;
      end
    end
  end

  assign serOut = shReg[0];

  always_comb begin
    if (rdRow < ROW_LIMIT)
      rdData = rdNv ? nvMem[rdRow] : sramMem[rdRow];
    else
      rdData = '0;
  end

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doShift |=> shReg[WORD_W-1] == $past(serIn));
  p_shift_out_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doShift |=> serOut == $past(shReg[1]));
  p_capture_hdr_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doCapture |=> $stable(shReg[DATA_LSB-1:0]));
  p_capture_oor_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doCapture && !addrOk) |=> $stable(shReg));
endmodule

// File: rtl/cfg_row_prog.sv
module cfg_row_prog
  import cfg_row_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftEn,
  input  logic              serIn,
  output logic              serOut,
  input  logic              updateStb,
  input  logic              captureStb,
  input  logic              targetNv,
  input  logic              bootCopy,
  output logic              copyBusy,
  input  logic              rdNv,
  input  logic [ADDR_W-1:0] rdRow,
  output logic [DATA_W-1:0] rdData
);
  ctrl_t ctl;

  cfg_row_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .updateStb(updateStb),
    .captureStb(captureStb), .targetNv(targetNv), .bootCopy(bootCopy),
    .ctl(ctl), .copyBusy(copyBusy)
  );

  cfg_row_store store_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .serIn(serIn), .serOut(serOut),
    .rdNv(rdNv), .rdRow(rdRow), .rdData(rdData)
  );
endmodule

// File: tb/cfg_row_prog_tb.sv
module cfg_row_prog_tb_top;
  localparam int NROW = 49;
  localparam int NW   = 274;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftEn = 0, serIn = 0, updateStb = 0, captureStb = 0;
  logic targetNv = 0, bootCopy = 0, rdNv = 0;
  logic [5:0]   rdRow = 0;
  logic         serOut, copyBusy;
  logic [259:0] rdData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5ns clk = ~clk;

  cfg_row_prog dut_i (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .serIn(serIn), .serOut(serOut),
    .updateStb(updateStb), .captureStb(captureStb), .targetNv(targetNv),
    .bootCopy(bootCopy), .copyBusy(copyBusy), .rdNv(rdNv), .rdRow(rdRow),
    .rdData(rdData)
  );

  // behavioural reference model
  bit           mq[$];
  logic [259:0] mSram [NROW];
  logic [259:0] mNv   [NROW];
  bit           mBusy;
  int           mRow;

  function automatic int qAddr();
    int a = 0;
    for (int i = 0; i < 6; i++) if (mq[8+i]) a += (1 << i);
    return a;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete();
      for (int i = 0; i < NW; i++) mq.push_back(1'b0);
      for (int r = 0; r < NROW; r++) begin mSram[r] = '0; mNv[r] = '0; end
      mBusy = 0; mRow = 0;
    end else begin
      automatic int a = qAddr();
      automatic logic [259:0] d, cap;
      automatic bit cp = captureStb && !mBusy;
      for (int j = 0; j < 260; j++) d[j] = mq[14+j];
      cap = '0;
      if (a < NROW) cap = targetNv ? mNv[a] : mSram[a];
      if (updateStb && !mBusy && a < NROW) begin
        if (targetNv) mNv[a] = d; else mSram[a] = d;
      end
      if (mBusy) begin
        mSram[mRow] = mNv[mRow];
        if (mRow == NROW-1) begin mBusy = 0; mRow = 0; end
        else mRow++;
      end else if (bootCopy) begin
        mBusy = 1; mRow = 0;
      end
      if (cp) begin
        if (a < NROW) for (int j = 0; j < 260; j++) mq[14+j] = cap[j];
      end else if (shiftEn) begin
        void'(mq.pop_front());
        mq.push_back(serIn);
      end
    end
  end

  task automatic chk(input string tag, input bit ok, input logic [273:0] act, input logic [273:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      automatic logic [259:0] e = '0;
      if (rdRow < NROW) e = rdNv ? mNv[rdRow] : mSram[rdRow];
      chk("R1 serOut vs model", serOut === mq[0], 274'(serOut), 274'(mq[0]));
      chk("R9 copyBusy vs model", copyBusy === mBusy, 274'(copyBusy), 274'(mBusy));
      chk("R3 rdData vs model", rdData === e, 274'(rdData), 274'(e));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic shiftWord(input logic [7:0] pad, input logic [5:0] a, input logic [259:0] d);
    logic [273:0] w = {d, a, pad};
    for (int i = 0; i < NW; i++) begin
      shiftEn = 1; serIn = w[i]; step();
    end
    shiftEn = 0; serIn = 0;
  endtask

  task automatic shiftOut(output logic [273:0] got);
    for (int i = 0; i < NW; i++) begin
      got[i] = serOut; shiftEn = 1; serIn = 0; step();
    end
    shiftEn = 0;
  endtask

  task automatic pulseUpd(input bit nv);
    targetNv = nv; updateStb = 1; step(); updateStb = 0;
  endtask

  task automatic rd(input bit nv, input int r, input logic [259:0] exp, input string tag);
    rdNv = nv; rdRow = 6'(r); #1;
    chk(tag, rdData === exp, 274'(rdData), 274'(exp));
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [259:0] pA, pB, pC;
    logic [273:0] got;
    int busyCnt;
    pA = 260'({9{32'hA5C3_0F17}});
    pB = 260'({9{32'h3E91_7BD2}});
    pC = 260'({9{32'h0F0F_C3A1}}) ^ {1'b1, 259'd0};

    repeat (3) step();
    rstN = 1; step();

    // R8: reset state
    rd(0, 0, '0, "R8 sram row0 zero");
    rd(1, 48, '0, "R8 nv row48 zero");
    chk("R8 serOut zero", serOut === 1'b0, 274'(serOut), 274'd0);

    // R2/R3: volatile write to row 5
    shiftWord(8'h00, 6'd5, pA);
    pulseUpd(0);
    rd(0, 5, pA, "R3 R2 sram row5 written");
    rd(1, 5, '0, "R4 nv row5 untouched by sram write");

    // R4: nonvolatile write to row 48
    shiftWord(8'hFF, 6'd48, pB);
    pulseUpd(1);
    rd(1, 48, pB, "R4 nv row48 written");
    rd(0, 48, '0, "R4 sram row48 untouched");

    // R6: padding ignored, same row, different pad
    shiftWord(8'h5A, 6'd5, pC);
    pulseUpd(0);
    rd(0, 5, pC, "R6 pad does not alter row/data");
    rd(0, 6, '0, "R6 neighbour row untouched");

    // R1: serial readback of the current word
    shiftOut(got);
    chk("R1 serOut returns shifted word", got === {pC, 6'd5, 8'h5A}, got, {pC, 6'd5, 8'h5A});

    // R5: out-of-range addresses
    shiftWord(8'h00, 6'd49, pA);
    pulseUpd(0); pulseUpd(1);
    shiftWord(8'h00, 6'd63, pA);
    pulseUpd(0); pulseUpd(1);
    for (int r = 0; r < NROW; r++) begin
      rd(0, r, mSram[r], "R5 sram rows unchanged by oor write");
      rd(1, r, mNv[r], "R5 nv rows unchanged by oor write");
    end
    rd(0, 5, pC, "R5 sram row5 keeps value");
    rd(0, 50, '0, "R8 read beyond rows gives zero");

    // R7: capture nv row 48, shiftEn also high (capture wins)
    shiftWord(8'h3C, 6'd48, '0);
    targetNv = 1; captureStb = 1; shiftEn = 1; serIn = 1; step();
    captureStb = 0; shiftEn = 0; serIn = 0;
    shiftOut(got);
    chk("R7 capture loads nv row, header kept", got === {pB, 6'd48, 8'h3C}, got, {pB, 6'd48, 8'h3C});

    // R9/R10: boot copy
    shiftWord(8'h00, 6'd0, pA);
    pulseUpd(1);
    shiftWord(8'h00, 6'd10, pC);
    bootCopy = 1; step(); bootCopy = 0;
    busyCnt = 0;
    targetNv = 0; updateStb = 1; captureStb = 1; bootCopy = 1; step();
    updateStb = 0; captureStb = 0; bootCopy = 0;
    busyCnt = 1;
    while (copyBusy && busyCnt < 200) begin step(); busyCnt++; end
    chk("R9 copyBusy lasts 49 cycles", busyCnt == 49, 274'(busyCnt), 274'd49);
    rd(0, 0, pA, "R9 sram row0 copied from nv");
    rd(0, 48, pB, "R9 sram row48 copied from nv");
    rd(0, 5, '0, "R9 sram row5 overwritten by nv row5");
    rd(0, 10, '0, "R10 update during copy ignored");
    shiftOut(got);
    chk("R10 capture during copy ignored", got === {pC, 6'd10, 8'h00}, got, {pC, 6'd10, 8'h00});
    repeat (3) step();
    chk("R10 bootCopy during copy ignored", copyBusy === 1'b0, 274'(copyBusy), 274'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule